// File: doc/BRIEF.md
# Read Write Erase Gating Controller

This block sits between the host's read, write and erase enables and the read/write channel of a disk drive. Write mode and erase current are passed on only when four conditions all hold: the host enable is present, the drive is selected and ready, the positioner is in position mode, and the drive is not file-protected. Read is qualified by selected-and-ready alone.

The block also flags when a write or erase is in progress. Two pieces of state are guarded by that flag. The first is a file-protect latch, which also feeds back into the write and erase gating. The second is a load-heads flip-flop. While the flag is active, requests to change protection or to unload the heads are held pending. They take effect at the first clock edge at which the flag is inactive.

Top module: `rw_gate_ctrl`

## Requirements
- R1: `wr_mode_no` is low exactly when `wr_en_i`, `sel_rdy_i` and `pos_mode_i` are all high and `protected_o` is low; otherwise it is high (combinational).
- R2: `er_cur_en_no` is low exactly when `er_en_i`, `sel_rdy_i` and `pos_mode_i` are all high and `protected_o` is low; otherwise it is high (combinational).
- R3: `rd_en_o` equals `rd_en_i` AND `sel_rdy_i`; neither `pos_mode_i` nor the protect state has any effect on it.
- R4: `wr_or_er_no` is low whenever `wr_en_i` or `er_en_i` (or both) is high, and high otherwise.
- R5: The protect state does not change at any clock edge at which `wr_en_i` or `er_en_i` is high. A set or clear request made in such a cycle is held pending, and a later request made while busy replaces it. The pending request is applied at the first edge with both enables low. A fresh request in that cycle takes precedence over the pending one.
- R6: `heads_loaded_o` is never cleared at an edge at which `wr_en_i` or `er_en_i` is high. An unload request made while busy is held pending and clears `heads_loaded_o` at the first edge with both enables low.
- R7: After reset, `protected_o` is 1 (protected) and `heads_loaded_o` is 0 (unloaded).
- R8: When `prot_set_i` and `prot_clr_i` are both high in the same cycle, the request is treated as a set.
- R9: `load_req_i` sets `heads_loaded_o` at the next edge whether busy or not, and cancels any pending unload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write enable |
| er_en_i | input | 1 | Host erase enable |
| rd_en_i | input | 1 | Host read enable |
| sel_rdy_i | input | 1 | Drive selected and ready |
| pos_mode_i | input | 1 | Positioner in position mode |
| prot_set_i | input | 1 | Request to enter file-protect |
| prot_clr_i | input | 1 | Request to leave file-protect |
| load_req_i | input | 1 | Request to load heads |
| unload_req_i | input | 1 | Request to unload heads |
| wr_mode_no | output | 1 | Gated write mode, active low |
| er_cur_en_no | output | 1 | Gated erase current enable, active low |
| rd_en_o | output | 1 | Gated read enable |
| wr_or_er_no | output | 1 | Write or erase in progress, active low |
| protected_o | output | 1 | File-protect state |
| heads_loaded_o | output | 1 | Heads loaded state |

## Verification
The hardest situation to reach is a pending request that is replaced, or cancelled, before the busy window closes. The outcome is visible only after the enables drop. The bench holds a write or an erase active across several cycles. During that window it issues a set followed by a clear, or an unload followed by a load. It samples the state at every busy cycle, and again on the cycle after the flag clears. A full sweep of all enable and status inputs is run under both protect states, so the feedback from the latch into the gating is covered.

// File: rtl/rw_gate_pkg.sv
package rw_gate_pkg;
  typedef enum logic [1:0] {
    PREQ_NONE = 2'd0,
    PREQ_SET  = 2'd1,
    PREQ_CLR  = 2'd2
  } prot_req_e;
endpackage

// File: rtl/rw_gate_logic.sv
module rw_gate_logic (
  input  logic wr_en_i,
  input  logic er_en_i,
  input  logic rd_en_i,
  input  logic sel_rdy_i,
  input  logic pos_mode_i,
  input  logic protected_i,
  output logic wr_mode_no,
  output logic er_cur_en_no,
  output logic rd_en_o,
  output logic busy_o
);
  logic qual;

  // shared qualifier for write and erase paths
  assign qual         = sel_rdy_i & pos_mode_i & ~protected_i;
  assign wr_mode_no   = ~(wr_en_i & qual);
  assign er_cur_en_no = ~(er_en_i & qual);
  assign rd_en_o      = rd_en_i & sel_rdy_i;
  assign busy_o       = wr_en_i | er_en_i;
endmodule

// File: rtl/rw_protect_latch.sv
module rw_protect_latch
  import rw_gate_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic set_i,
  input  logic clr_i,
  output logic protected_o
);
  prot_req_e fresh, eff, pend_q, pend_d;
  logic      prot_q, prot_d;

  always_comb begin
    if (set_i)      fresh = PREQ_SET;
    else if (clr_i) fresh = PREQ_CLR;
    else            fresh = PREQ_NONE;
    eff = (fresh != PREQ_NONE) ? fresh : pend_q;
  end

  always_comb begin
    prot_d = prot_q;
    pend_d = PREQ_NONE;
    if (busy_i) begin
      pend_d = eff;
    end else begin
      unique case (eff)
        PREQ_SET: prot_d = 1'b1;
        PREQ_CLR: prot_d = 1'b0;
        default:  prot_d = prot_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= RST_VAL;
      pend_q <= PREQ_NONE;
    end else begin
      prot_q <= prot_d;
      pend_q <= pend_d;
    end
  end

  assign protected_o = prot_q;

  p_prot_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(prot_q));
  p_pend_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (pend_q == PREQ_NONE));
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i && !busy_i) |=> prot_q);
endmodule

// File: rtl/rw_heads_ctl.sv
module rw_heads_ctl #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic load_i,
  input  logic unload_i,
  output logic loaded_o
);
  logic loaded_q, loaded_d;
  logic unl_pend_q, unl_pend_d;

  always_comb begin
    loaded_d   = loaded_q;
    unl_pend_d = unl_pend_q;
    if (load_i) begin
      loaded_d   = 1'b1;
      unl_pend_d = 1'b0;
    end else if (busy_i) begin
      unl_pend_d = unl_pend_q | unload_i;
    end else begin
      if (unload_i || unl_pend_q) loaded_d = 1'b0;
      unl_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q   <= RST_VAL;
      unl_pend_q <= 1'b0;
    end else begin
      loaded_q   <= loaded_d;
      unl_pend_q <= unl_pend_d;
    end
  end

  assign loaded_o = loaded_q;

  p_no_unload_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !$fell(loaded_q));
  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (loaded_q && !unl_pend_q));
endmodule

// File: rtl/rw_gate_ctrl.sv
module rw_gate_ctrl #(
  parameter logic PROT_RST  = 1'b1,
  parameter logic HEADS_RST = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic er_en_i,
  input  logic rd_en_i,
  input  logic sel_rdy_i,
  input  logic pos_mode_i,
  input  logic prot_set_i,
  input  logic prot_clr_i,
  input  logic load_req_i,
  input  logic unload_req_i,
  output logic wr_mode_no,
  output logic er_cur_en_no,
  output logic rd_en_o,
  output logic wr_or_er_no,
  output logic protected_o,
  output logic heads_loaded_o
);
  logic busy;
  logic prot;

  rw_gate_logic i_gate (
    .wr_en_i      (wr_en_i),
    .er_en_i      (er_en_i),
    .rd_en_i      (rd_en_i),
    .sel_rdy_i    (sel_rdy_i),
    .pos_mode_i   (pos_mode_i),
    .protected_i  (prot),
    .wr_mode_no   (wr_mode_no),
    .er_cur_en_no (er_cur_en_no),
    .rd_en_o      (rd_en_o),
    .busy_o       (busy)
  );

  rw_protect_latch #(.RST_VAL(PROT_RST)) i_prot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .set_i       (prot_set_i),
    .clr_i       (prot_clr_i),
    .protected_o (prot)
  );

  rw_heads_ctl #(.RST_VAL(HEADS_RST)) i_heads (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy),
    .load_i   (load_req_i),
    .unload_i (unload_req_i),
    .loaded_o (heads_loaded_o)
  );

  assign wr_or_er_no = ~busy;
  assign protected_o = prot;

  p_wr_qual_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode_no |-> (wr_en_i && sel_rdy_i && pos_mode_i && !protected_o));
  p_er_qual_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !er_cur_en_no |-> (er_en_i && sel_rdy_i && pos_mode_i && !protected_o));
  p_rd_qual_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_en_i && sel_rdy_i));
  p_flag_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !er_en_i) |-> wr_or_er_no);
endmodule

// File: tb/test_rw_gate_ctrl.sv
`timescale 1ns/1ps
module test_rw_gate_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, er_en = 0, rd_en = 0, sel_rdy = 0, pos_mode = 0;
  logic p_set = 0, p_clr = 0, load = 0, unload = 0;
  logic wr_mode_n, er_cur_n, rd_out, woe_n, prot, loaded;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rw_gate_ctrl i_rw_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .er_en_i(er_en), .rd_en_i(rd_en),
    .sel_rdy_i(sel_rdy), .pos_mode_i(pos_mode),
    .prot_set_i(p_set), .prot_clr_i(p_clr),
    .load_req_i(load), .unload_req_i(unload),
    .wr_mode_no(wr_mode_n), .er_cur_en_no(er_cur_n), .rd_en_o(rd_out),
    .wr_or_er_no(woe_n), .protected_o(prot), .heads_loaded_o(loaded)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R7 protect", prot, 1'b1);
    chk("R7 heads", loaded, 1'b0);
  endtask

  task automatic set_prot(input logic v);
    wr_en = 0; er_en = 0;
    p_set = v; p_clr = ~v;
    cyc();
    p_set = 0; p_clr = 0;
    chk("R5 prot setup", prot, v);
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 2; p++) begin
      set_prot(p[0]);
      for (int c = 0; c < 32; c++) begin
        cyc();
        {wr_en, er_en, rd_en, sel_rdy, pos_mode} = c[4:0];
        #1;
        chk("R1 wr_mode", wr_mode_n, ~(wr_en & sel_rdy & pos_mode & ~p[0]));
        chk("R2 er_cur", er_cur_n, ~(er_en & sel_rdy & pos_mode & ~p[0]));
        chk("R3 rd_en", rd_out, rd_en & sel_rdy);
        chk("R4 flag", woe_n, ~(wr_en | er_en));
      end
      cyc();
      wr_en = 0; er_en = 0; rd_en = 0; sel_rdy = 0; pos_mode = 0;
      cyc();
      chk("R5 prot kept through sweep", prot, p[0]);
    end
  endtask

  task automatic t_prot_lock();
    set_prot(1'b1);
    wr_en = 1;
    p_clr = 1;
    cyc();
    p_clr = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R5 hold while write", prot, 1'b1);
      cyc();
    end
    wr_en = 0;
    cyc();
    chk("R5 pending clear applied", prot, 1'b0);
    // replacement while erasing: set then clear, clear must win
    er_en = 1; p_set = 1;
    cyc();
    p_set = 0; p_clr = 1;
    cyc();
    p_clr = 0;
    chk("R5 hold while erase", prot, 1'b0);
    cyc();
    er_en = 0;
    cyc();
    chk("R5 later pending replaces", prot, 1'b0);
    // fresh request at release edge beats pending
    wr_en = 1; p_clr = 1;
    cyc();
    set_prot(1'b1);
    chk("R5 fresh overrides pending", prot, 1'b1);
  endtask

  task automatic t_set_wins();
    set_prot(1'b0);
    p_set = 1; p_clr = 1;
    cyc();
    p_set = 0; p_clr = 0;
    chk("R8 set wins idle", prot, 1'b1);
    set_prot(1'b0);
    wr_en = 1; p_set = 1; p_clr = 1;
    cyc();
    p_set = 0; p_clr = 0;
    chk("R8 busy hold", prot, 1'b0);
    wr_en = 0;
    cyc();
    chk("R8 set wins pending", prot, 1'b1);
  endtask

  task automatic t_heads();
    load = 1;
    cyc();
    load = 0;
    chk("R9 load idle", loaded, 1'b1);
    er_en = 1; unload = 1;
    cyc();
    unload = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R6 no unload while busy", loaded, 1'b1);
      cyc();
    end
    er_en = 0;
    cyc();
    chk("R6 pending unload applied", loaded, 1'b0);
    wr_en = 1; load = 1;
    cyc();
    load = 0;
    chk("R9 load while busy", loaded, 1'b1);
    unload = 1;
    cyc();
    unload = 0; load = 1;
    cyc();
    load = 0; wr_en = 0;
    cyc();
    chk("R9 load cancels pending unload", loaded, 1'b1);
    unload = 1;
    cyc();
    unload = 0;
    chk("R6 idle unload", loaded, 1'b0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc();
    cyc();
    t_reset();
    rst_n = 1;
    cyc();
    t_reset();
    t_sweep();
    t_prot_lock();
    t_set_wins();
    t_heads();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule